// File: doc/BRIEF.md
# Smart-Card Speed Negotiation Tracker

This block listens, without driving anything, to the byte stream exchanged on a smart-card I/O line once the card leaves reset. A receiver in front of it delivers each character as a one-cycle strobe with its 8-bit value. The tracker walks through the card's answer to reset: the sync character, the format character, the chained interface characters, the historical characters and the optional check character. It then follows the reader's parameter-selection request and the card's reply. It discards optional characters according to presence bits it captures while running.

When the card's reply confirms an enhanced transfer speed, the tracker keeps the 2-bit speed multiplier code from the reply and raises a one-cycle switch pulse as the reply's closing character arrives. Anything unexpected sends it to a terminal state, which it leaves only through the card reset. The done flag marks that terminal state, so the surrounding logic knows that no further switch can follow in this session.

Top module: `card_speed_tracker`

## Requirements
- R1: While card_rst_n is low, trk_done, spd_switch and spd_mult are all 0. The first character after reset must be 8'h3B. Any other value makes trk_done rise and stay high.
- R2: In the format character (the one after 8'h3B), bits 7:4 are the presence mask and bits 3:0 are the historical-character count. Mask bit 4 means an A-character follows, bit 5 a B-character, bit 6 a C-character and bit 7 a D-character.
- R3: The A, B and C interface positions each consume exactly one character when their mask bit is 1. When the bit is 0 they are passed in one clock with no character.
- R4: A D-character replaces the presence mask with its own bits 7:4 and starts a new A/B/C/D group. If its bits 3:0 are nonzero, a check character becomes expected. With mask bit 7 clear, the tracker moves on to the historical characters.
- R5: Exactly as many historical characters are consumed as the format character's count, and any value is accepted, 8'hFF included. One check character then follows, but only if some D-character had nonzero bits 3:0.
- R6: The request must start with 8'hFF, or trk_done rises. Bits 4, 5 and 6 of the request's next character select whether parameter characters 1, 2 and 3 follow. After those, exactly one closing character of any value is consumed.
- R7: The reply must start with 8'hFF, or trk_done rises. If request bit 4 was 0, trk_done rises on the reply's next character. Otherwise that character's bits 4, 5 and 6 replace the presence bits for the rest of the reply.
- R8: The reply's first parameter character must have bits 7:2 equal to 6'b100101, or trk_done rises and spd_mult is left unchanged. On a match, its bits 1:0 load spd_mult. spd_mult then keeps that value until card_rst_n goes low.
- R9: The reply's closing character, after its optional parameter characters 2 and 3, makes spd_switch high for exactly one cycle. This is the cycle after the clock edge that sampled the character, and trk_done rises in that same cycle. Later characters cause no further pulse and do not clear trk_done.
- R10: A character whose strobe lands while the tracker is passing an absent position is held and consumed by the next position that takes a character. A strobe that lands while a held character is being consumed is held in turn. Only one character is held at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| card_rst_n | input | 1 | Card reset line, active low; holds the tracker at its start |
| rx_stb | input | 1 | One-cycle strobe: a received character is present |
| rx_byte | input | 8 | Value of the received character |
| spd_switch | output | 1 | One-cycle pulse when the enhanced speed is confirmed |
| spd_mult | output | 2 | Captured speed multiplier code |
| trk_done | output | 1 | Tracker is in its terminal state |

## Verification
Two events can coincide with a character strobe. A strobe can land in a cycle where the tracker is passing an absent interface position, and a strobe can land in the very cycle a held character is being consumed. The bench provokes both by sending the request's start character two clocks after an all-absent format character, and the request's next character on the exact edge where the held one is taken. Losing or reordering either character would make the request start check fail or shift every later character by one. The bench judges this from the done flag staying low and from the final switch pulse and multiplier code.

// File: rtl/cst_pkg.sv
package cst_pkg;

  localparam int NIB_W    = 4;
  localparam int BYTE_W   = 2 * NIB_W;
  localparam int PPS_BITS = 3;
  localparam int MULT_W   = 2;
  localparam int TAG_W    = BYTE_W - MULT_W;

  localparam logic [BYTE_W-1:0] SYNC_CHAR  = 8'h3B;
  localparam logic [BYTE_W-1:0] START_CHAR = 8'hFF;
  localparam logic [TAG_W-1:0]  ACK_TAG    = 6'b100101;

  typedef enum logic [4:0] {
    ST_SYNC, ST_FMT, ST_IA, ST_IB, ST_IC, ST_ID, ST_HIST, ST_CHK,
    ST_QSTART, ST_Q0, ST_Q1, ST_Q2, ST_Q3, ST_QEND,
    ST_RSTART, ST_R0, ST_R1, ST_R2, ST_R3, ST_REND,
    ST_DONE
  } st_e;

  typedef struct packed {
    logic [NIB_W-1:0] hi;
    logic [NIB_W-1:0] lo;
  } nib_pair_t;

  typedef struct packed {
    logic              ok;
    logic [MULT_W-1:0] code;
  } ack_t;

  function automatic nib_pair_t split_byte(input logic [BYTE_W-1:0] b);
    nib_pair_t r;
    r.hi = b[BYTE_W-1:NIB_W];
    r.lo = b[NIB_W-1:0];
    return r;
  endfunction

  function automatic ack_t decode_ack(input logic [BYTE_W-1:0] b);
    ack_t r;
    r.ok   = (b[BYTE_W-1:MULT_W] == ACK_TAG);
    r.code = b[MULT_W-1:0];
    return r;
  endfunction

  // 1 when the state has to wait for a character, 0 when it passes in one clock
  function automatic logic st_needs(input st_e s, input logic [NIB_W-1:0] pres,
                                    input logic [NIB_W-1:0] hcnt, input logic chk,
                                    input logic [PPS_BITS-1:0] pm);
    logic r;
    case (s)
      ST_IA:   r = pres[0];
      ST_IB:   r = pres[1];
      ST_IC:   r = pres[2];
      ST_ID:   r = pres[3];
      ST_HIST: r = (hcnt != '0);
      ST_CHK:  r = chk;
      ST_Q1:   r = pm[0];
      ST_Q2:   r = pm[1];
      ST_Q3:   r = pm[2];
      ST_R2:   r = pm[1];
      ST_R3:   r = pm[2];
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic st_e skip_next(input st_e s);
    st_e r;
    case (s)
      ST_IA:   r = ST_IB;
      ST_IB:   r = ST_IC;
      ST_IC:   r = ST_ID;
      ST_ID:   r = ST_HIST;
      ST_HIST: r = ST_CHK;
      ST_CHK:  r = ST_QSTART;
      ST_Q1:   r = ST_Q2;
      ST_Q2:   r = ST_Q3;
      ST_Q3:   r = ST_QEND;
      ST_R2:   r = ST_R3;
      ST_R3:   r = ST_REND;
      default: r = s;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cst_hold.sv
module cst_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic         cur_vld,
  output logic [W-1:0] cur_val
);

  logic         held_q;
  logic [W-1:0] hval_q;

  assign cur_vld = held_q | stb;
  assign cur_val = held_q ? hval_q : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      hval_q <= '0;
    end else if (held_q) begin
      if (take) begin
        held_q <= stb;
        if (stb) hval_q <= din;
      end
    end else if (stb && !take) begin
      held_q <= 1'b1;
      hval_q <= din;
    end
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !take) |=> (held_q && $stable(hval_q))); // R10
  AST_HOLD_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !held_q && !take) |=> (held_q && hval_q == $past(din))); // R10
  AST_HOLD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && take && stb) |=> (held_q && hval_q == $past(din))); // R10

endmodule

// File: rtl/cst_walk.sv
module cst_walk
  import cst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [BYTE_W-1:0] in_val,
  output logic              take,
  output logic              cap_en,
  output logic [MULT_W-1:0] cap_code,
  output logic              fire,
  output logic              done
);

  st_e                 st_q, st_n;
  logic [NIB_W-1:0]    pres_q, pres_n;
  logic [NIB_W-1:0]    hcnt_q, hcnt_n;
  logic                chk_q, chk_n;
  logic [PPS_BITS-1:0] pm_q, pm_n;
  logic                need;
  logic                skip_evt;
  nib_pair_t           sp;
  ack_t                ak;

  assign sp       = split_byte(in_val);
  assign ak       = decode_ack(in_val);
  assign need     = st_needs(st_q, pres_q, hcnt_q, chk_q, pm_q);
  assign take     = need & in_vld;
  assign skip_evt = ~need;
  assign cap_code = ak.code;
  assign done     = (st_q == ST_DONE);

  always_comb begin
    st_n   = st_q;
    pres_n = pres_q;
    hcnt_n = hcnt_q;
    chk_n  = chk_q;
    pm_n   = pm_q;
    cap_en = 1'b0;
    fire   = 1'b0;
    if (skip_evt) begin
      st_n = skip_next(st_q);
    end else if (in_vld) begin
      case (st_q)
        ST_SYNC:   st_n = (in_val == SYNC_CHAR) ? ST_FMT : ST_DONE;
        ST_FMT: begin
          pres_n = sp.hi;
          hcnt_n = sp.lo;
          st_n   = ST_IA;
        end
        ST_IA:     st_n = ST_IB;
        ST_IB:     st_n = ST_IC;
        ST_IC:     st_n = ST_ID;
        ST_ID: begin
          pres_n = sp.hi;
          if (sp.lo != '0) chk_n = 1'b1;
          st_n   = ST_IA;
        end
        ST_HIST:   hcnt_n = hcnt_q - 1'b1;
        ST_CHK:    st_n = ST_QSTART;
        ST_QSTART: st_n = (in_val == START_CHAR) ? ST_Q0 : ST_DONE;
        ST_Q0: begin
          pm_n = sp.hi[PPS_BITS-1:0];
          st_n = ST_Q1;
        end
        ST_Q1:     st_n = ST_Q2;
        ST_Q2:     st_n = ST_Q3;
        ST_Q3:     st_n = ST_QEND;
        ST_QEND:   st_n = ST_RSTART;
        ST_RSTART: st_n = (in_val == START_CHAR) ? ST_R0 : ST_DONE;
        ST_R0: begin
          if (!pm_q[0]) begin
            st_n = ST_DONE;
          end else begin
            pm_n = sp.hi[PPS_BITS-1:0];
            st_n = ST_R1;
          end
        end
        ST_R1: begin
          if (!ak.ok) begin
            st_n = ST_DONE;
          end else begin
            cap_en = 1'b1;
            st_n   = ST_R2;
          end
        end
        ST_R2:     st_n = ST_R3;
        ST_R3:     st_n = ST_REND;
        ST_REND: begin
          fire = 1'b1;
          st_n = ST_DONE;
        end
        default:   st_n = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SYNC;
      pres_q <= '0;
      hcnt_q <= '0;
      chk_q  <= 1'b0;
      pm_q   <= '0;
    end else begin
      st_q   <= st_n;
      pres_q <= pres_n;
      hcnt_q <= hcnt_n;
      chk_q  <= chk_n;
      pm_q   <= pm_n;
    end
  end

  AST_SYNC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SYNC && take && in_val != SYNC_CHAR) |=> (st_q == ST_DONE)); // R1
  AST_SKIP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt |=> (st_q != $past(st_q))); // R3
  AST_HIST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HIST && take) |=> (hcnt_q == $past(hcnt_q) - 1'b1)); // R5
  AST_REQ_NO_P1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_R0 && take && !pm_q[0]) |=> (st_q == ST_DONE)); // R7
  AST_ACK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_R1 && take && !ak.ok) |=> (st_q == ST_DONE)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> (st_q == ST_DONE)); // R9

endmodule

// File: rtl/cst_speed.sv
module cst_speed #(
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [MW-1:0] cap_code,
  input  logic          fire,
  output logic [MW-1:0] mult,
  output logic          sw
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult <= '0;
      sw   <= 1'b0;
    end else begin
      sw <= fire;
      if (cap_en) mult <= cap_code;
    end
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    sw |=> !sw); // R9
  AST_MULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(mult)); // R8

endmodule

// File: rtl/card_speed_tracker.sv
module card_speed_tracker
  import cst_pkg::*;
(
  input  logic              clk,
  input  logic              card_rst_n,
  input  logic              rx_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              spd_switch,
  output logic [MULT_W-1:0] spd_mult,
  output logic              trk_done
);

  logic              cur_vld;
  logic [BYTE_W-1:0] cur_val;
  logic              take;
  logic              cap_en;
  logic [MULT_W-1:0] cap_code;
  logic              fire;

  cst_hold #(.W(BYTE_W)) i_hold (
    .clk     (clk),
    .rst_n   (card_rst_n),
    .stb     (rx_stb),
    .din     (rx_byte),
    .take    (take),
    .cur_vld (cur_vld),
    .cur_val (cur_val)
  );

  cst_walk i_walk (
    .clk      (clk),
    .rst_n    (card_rst_n),
    .in_vld   (cur_vld),
    .in_val   (cur_val),
    .take     (take),
    .cap_en   (cap_en),
    .cap_code (cap_code),
    .fire     (fire),
    .done     (trk_done)
  );

  cst_speed #(.MW(MULT_W)) i_speed (
    .clk      (clk),
    .rst_n    (card_rst_n),
    .cap_en   (cap_en),
    .cap_code (cap_code),
    .fire     (fire),
    .mult     (spd_mult),
    .sw       (spd_switch)
  );

  AST_SW_WITH_DONE: assert property (@(posedge clk) disable iff (!card_rst_n)
    spd_switch |-> trk_done); // R9

endmodule

// File: tb/test_card_speed_tracker.sv
module test_card_speed_tracker;

  logic       clk = 1'b0;
  logic       card_rst_n = 1'b0;
  logic       rx_stb = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       spd_switch;
  logic [1:0] spd_mult;
  logic       trk_done;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int base = 0;
  bit finished = 1'b0;

  typedef struct {
    string      tag;
    logic       done;
    logic [1:0] mult;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  card_speed_tracker i_card_speed_tracker (
    .clk        (clk),
    .card_rst_n (card_rst_n),
    .rx_stb     (rx_stb),
    .rx_byte    (rx_byte),
    .spd_switch (spd_switch),
    .spd_mult   (spd_mult),
    .trk_done   (trk_done)
  );

  always @(posedge clk) if (card_rst_n && spd_switch) pulses <= pulses + 1;

  task automatic check_eq(input string tg, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tg, act, exp);
    end
  endtask

  // driver: one character, then gap idle cycles, then the expected state
  task automatic send(input logic [7:0] v, input int gap, input logic ed,
                      input logic [1:0] em, input string tg);
    exp_t e;
    @(negedge clk);
    rx_stb  = 1'b1;
    rx_byte = v;
    @(negedge clk);
    rx_stb  = 1'b0;
    repeat (gap) @(negedge clk);
    e.tag  = tg;
    e.done = ed;
    e.mult = em;
    sb.push_back(e);
  endtask

  // final reply character: pulse and done in the cycle after the sampling edge
  task automatic send_last(input logic [7:0] v, input logic [1:0] em);
    @(negedge clk);
    rx_stb  = 1'b1;
    rx_byte = v;
    @(negedge clk);
    rx_stb  = 1'b0;
    check_eq("R9 switch high after closing char", int'(spd_switch), 1);
    check_eq("R9 done with switch", int'(trk_done), 1);
    check_eq("R8 mult at switch", int'(spd_mult), int'(em));
    @(negedge clk);
    check_eq("R9 switch one cycle", int'(spd_switch), 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    card_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 reset done", int'(trk_done), 0);
    check_eq("R1 reset switch", int'(spd_switch), 0);
    check_eq("R1 reset mult", int'(spd_mult), 0);
    card_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    base = pulses;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check_eq("scoreboard drained", sb.size(), 0);
  endtask

  // monitor: pop and compare expected items
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        e = sb.pop_front();
        check_eq({e.tag, " done"}, int'(trk_done), int'(e.done));
        check_eq({e.tag, " mult"}, int'(spd_mult), int'(e.mult));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();

    // S1: all-absent format, characters landing in skip cycles (R10, R2, R3)
    send(8'h3B, 0, 1'b0, 2'd0, "R1 sync ok");
    send(8'h00, 0, 1'b0, 2'd0, "R2 format empty");
    send(8'hFF, 3, 1'b0, 2'd0, "R10 start held in skip");
    send(8'h10, 8, 1'b0, 2'd0, "R10 chained hold");
    send(8'h11, 8, 1'b0, 2'd0, "R6 req p1");
    send(8'h5A, 8, 1'b0, 2'd0, "R6 req close");
    send(8'hFF, 8, 1'b0, 2'd0, "R7 reply start");
    send(8'h10, 8, 1'b0, 2'd0, "R7 reply p0");
    send(8'h95, 8, 1'b0, 2'd1, "R8 mult 01");
    send_last(8'h3C, 2'd1);
    send(8'hFF, 8, 1'b1, 2'd1, "R9 done sticky");
    send(8'h3B, 8, 1'b1, 2'd1, "R8 mult kept");
    drain();
    check_eq("R9 single pulse S1", pulses - base, 1);

    // S2: wrong sync character (R1)
    do_reset();
    send(8'h3F, 8, 1'b1, 2'd0, "R1 bad sync");
    send(8'hFF, 8, 1'b1, 2'd0, "R1 stays done");
    drain();
    check_eq("R1 no pulse", pulses - base, 0);

    // S3: full interface chain, counted history, check char (R2..R7)
    do_reset();
    send(8'h3B, 8, 1'b0, 2'd0, "R1 sync ok");
    send(8'hF2, 8, 1'b0, 2'd0, "R2 format all present");
    send(8'h11, 8, 1'b0, 2'd0, "R3 A");
    send(8'h22, 8, 1'b0, 2'd0, "R3 B");
    send(8'h33, 8, 1'b0, 2'd0, "R3 C");
    send(8'h81, 8, 1'b0, 2'd0, "R4 D only-D next");
    send(8'h01, 8, 1'b0, 2'd0, "R4 second D");
    send(8'hFF, 8, 1'b0, 2'd0, "R5 hist 1");
    send(8'hFF, 8, 1'b0, 2'd0, "R5 hist 2");
    send(8'hFF, 8, 1'b0, 2'd0, "R5 check char");
    send(8'hFF, 8, 1'b0, 2'd0, "R6 req start");
    send(8'h70, 8, 1'b0, 2'd0, "R6 req p0");
    send(8'h13, 8, 1'b0, 2'd0, "R6 req p1");
    send(8'h22, 8, 1'b0, 2'd0, "R6 req p2");
    send(8'h33, 8, 1'b0, 2'd0, "R6 req p3");
    send(8'h44, 8, 1'b0, 2'd0, "R6 req close");
    send(8'hFF, 8, 1'b0, 2'd0, "R7 reply start");
    send(8'h30, 8, 1'b0, 2'd0, "R7 reply p0 relatch");
    send(8'h97, 8, 1'b0, 2'd3, "R8 mult 11");
    send(8'h00, 8, 1'b0, 2'd3, "R7 reply p2");
    send_last(8'hAA, 2'd3);
    drain();
    check_eq("R9 single pulse S3", pulses - base, 1);

    // S4: request without parameter 1 (R7)
    do_reset();
    send(8'h3B, 8, 1'b0, 2'd0, "R1 sync ok");
    send(8'h00, 8, 1'b0, 2'd0, "R2 format empty");
    send(8'hFF, 8, 1'b0, 2'd0, "R6 req start");
    send(8'h00, 8, 1'b0, 2'd0, "R6 req p0 none");
    send(8'h12, 8, 1'b0, 2'd0, "R6 req close any");
    send(8'hFF, 8, 1'b0, 2'd0, "R7 reply start");
    send(8'h10, 8, 1'b1, 2'd0, "R7 no p1 in request");
    drain();
    check_eq("R7 no pulse", pulses - base, 0);

    // S5: reply tag mismatch (R8)
    do_reset();
    send(8'h3B, 8, 1'b0, 2'd0, "R1 sync ok");
    send(8'h00, 8, 1'b0, 2'd0, "R2 format empty");
    send(8'hFF, 8, 1'b0, 2'd0, "R6 req start");
    send(8'h10, 8, 1'b0, 2'd0, "R6 req p0");
    send(8'h11, 8, 1'b0, 2'd0, "R6 req p1");
    send(8'h22, 8, 1'b0, 2'd0, "R6 req close");
    send(8'hFF, 8, 1'b0, 2'd0, "R7 reply start");
    send(8'h10, 8, 1'b0, 2'd0, "R7 reply p0");
    send(8'h55, 8, 1'b1, 2'd0, "R8 tag mismatch");
    drain();
    check_eq("R8 no pulse", pulses - base, 0);

    // S6: request start wrong (R6)
    do_reset();
    send(8'h3B, 8, 1'b0, 2'd0, "R1 sync ok");
    send(8'h00, 8, 1'b0, 2'd0, "R2 format empty");
    send(8'hFE, 8, 1'b1, 2'd0, "R6 bad req start");
    drain();

    // S7: reply start wrong (R7)
    do_reset();
    send(8'h3B, 8, 1'b0, 2'd0, "R1 sync ok");
    send(8'h00, 8, 1'b0, 2'd0, "R2 format empty");
    send(8'hFF, 8, 1'b0, 2'd0, "R6 req start");
    send(8'h00, 8, 1'b0, 2'd0, "R6 req p0 none");
    send(8'h12, 8, 1'b0, 2'd0, "R6 req close");
    send(8'h00, 8, 1'b1, 2'd0, "R7 bad reply start");
    drain();

    // S8: D-character with zero low nibble, no check char (R4, R5)
    do_reset();
    send(8'h3B, 8, 1'b0, 2'd0, "R1 sync ok");
    send(8'h80, 8, 1'b0, 2'd0, "R2 format D only");
    send(8'h00, 8, 1'b0, 2'd0, "R4 D no check");
    send(8'hFF, 8, 1'b0, 2'd0, "R5 no check char");
    send(8'h10, 8, 1'b0, 2'd0, "R6 req p0");
    send(8'h11, 8, 1'b0, 2'd0, "R6 req p1");
    send(8'h12, 8, 1'b0, 2'd0, "R6 req close");
    send(8'hFF, 8, 1'b0, 2'd0, "R7 reply start");
    send(8'h10, 8, 1'b0, 2'd0, "R7 reply p0");
    send(8'h96, 8, 1'b0, 2'd2, "R8 mult 10");
    send_last(8'h77, 2'd2);
    drain();
    check_eq("R9 single pulse S8", pulses - base, 1);

    // reset clears captured multiplier (R1, R8)
    do_reset();
    check_eq("R8 mult cleared by reset", int'(spd_mult), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule